// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Showahead FIFO

This block moves a byte stream from one clock domain into another that has no phase or frequency relationship to the first. The producer pushes one 8-bit byte per write-clock edge. The consumer sees 32-bit words, each made of four consecutive bytes. The buffer holds 2048 bytes, which is 512 words. The consumer side works in first-word fall-through fashion. Whenever a complete word is waiting, it is already on the output bus. A read request takes that word and moves the output on to the next one.

Each domain has its own flags and occupancy count, kept in its own units: bytes on the producer side and words on the consumer side. A count is built from the local pointer and a synchronized copy of the remote pointer. It can lag the truth in the safe direction, but it never runs ahead of it. A push while full is dropped, and a pop while empty is dropped. Neither one disturbs the pointers. Each domain takes its own asynchronous reset. The reset is released synchronously inside the block.

Top module: `mw_async_fifo`

## Requirements
- R1: After reset the write side shows wr_full=0 and wr_used=0. The read side shows rd_empty=1 and rd_used=0.
- R2: A word stays hidden until all four of its bytes are accepted. With 1 to 3 bytes of a new word written, rd_empty stays 1 and rd_used does not count that word.
- R3: Pointers cross domains in Gray code, changing at most one bit per step, through two-stage synchronizers. A word whose last byte is accepted on a write edge is visible on the read side within 3 later read-clock edges.
- R4: The output word puts the first byte written in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24]. When rd_empty=0 the oldest word is on rd_data before rd_req is raised. It stays there until a read is accepted, and one accepted read moves to the next word.
- R5: A write request while wr_full=1 is ignored. It changes neither the stored data nor the write pointer, so wr_used stays 2048 and later words keep their byte alignment.
- R6: A read request while rd_empty=1 is ignored. The read pointer does not move, and rd_used stays 0 instead of wrapping to its maximum.
- R7: wr_used is bytes written minus bytes freed by reads, in the range 0 to 2048, and wr_full=1 exactly when it is 2048. rd_used is complete words waiting, in the range 0 to 512. After a full drain and settling, both counts return to 0.
- R8: A fill of 2048 bytes followed by a drain of 512 words returns every byte in the order written, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain reset, active low, asynchronous assert |
| wr_req | input | 1 | Push one byte on this write edge |
| wr_data | input | 8 | Byte to push |
| wr_full | output | 1 | No room for another byte |
| wr_used | output | 12 | Occupancy in bytes, as seen by the producer |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-domain reset, active low, asynchronous assert |
| rd_req | input | 1 | Accept the word on rd_data and advance |
| rd_data | output | 32 | Oldest complete word (fall-through) |
| rd_empty | output | 1 | No complete word waiting |
| rd_used | output | 10 | Complete words waiting, as seen by the consumer |

## Verification
A read pointer that advances while empty shows up on the very next read edge. It appears as an rd_used wrap or as rd_data that no longer matches the next expected word. A write pointer that moves while full misaligns every later word by a byte lane, and the first post-drain word shows it. A synchronizer or Gray-conversion fault shows as rd_empty staying set beyond the three-edge visibility window. It can also show as a count that fails to return to zero after a drain. A packing fault shows at once in the first word's lane order.

// File: rtl/mwf_pkg.sv
`timescale 1ns/1ps
package mwf_pkg;
   localparam int unsigned CW = 32;

   function automatic logic [CW-1:0] to_gray(input logic [CW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [CW-1:0] from_gray(input logic [CW-1:0] g);
      logic [CW-1:0] b;
      b = g;
      for (int s = 1; s < CW; s = s * 2) b = b ^ (b >> s);
      return b;
   endfunction
endpackage

// File: rtl/mwf_rst_sync.sv
`timescale 1ns/1ps
module mwf_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   logic [STAGES-1:0] chain;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end
   assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/mwf_sync2.sv
`timescale 1ns/1ps
module mwf_sync2 #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/mwf_wr_side.sv
`timescale 1ns/1ps
module mwf_wr_side
   import mwf_pkg::*;
#(
   parameter int unsigned AW = 11,
   parameter int unsigned LW = 2,
   parameter int unsigned DEPTH = 2048
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [AW-LW:0]  rq_gray,
   output logic            wen,
   output logic [AW-1:0]   waddr,
   output logic [AW:0]     wptr,
   output logic [AW-LW:0]  wgray,
   output logic            full,
   output logic [AW:0]     used
);
   localparam int unsigned PW = AW - LW + 1;

   logic [CW-1:0] rq_wide;
   logic [PW-1:0] rq_bin;
   logic [AW:0]   rq_bytes;
   logic [AW:0]   wptr_nx;
   logic [CW-1:0] g_wide;

   assign rq_wide  = from_gray(CW'(rq_gray));
   assign rq_bin   = rq_wide[PW-1:0];
   assign rq_bytes = {rq_bin, {LW{1'b0}}};
   assign used     = wptr - rq_bytes;
   assign full     = (used == (AW+1)'(DEPTH));
   assign wen      = req && !full;
   assign waddr    = wptr[AW-1:0];
   assign wptr_nx  = wptr + (AW+1)'(1);
   assign g_wide   = to_gray(CW'(wptr_nx[AW:LW]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
      end else if (wen) begin
         wptr  <= wptr_nx;
         wgray <= g_wide[PW-1:0];
      end
   end
endmodule

// File: rtl/mwf_rd_side.sv
`timescale 1ns/1ps
module mwf_rd_side
   import mwf_pkg::*;
#(
   parameter int unsigned PW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [PW-1:0] wq_gray,
   output logic [PW-1:0] rptr,
   output logic [PW-1:0] rgray,
   output logic          empty,
   output logic [PW-1:0] used
);
   logic [CW-1:0] wq_wide;
   logic [PW-1:0] wq_bin;
   logic [PW-1:0] rptr_nx;
   logic [CW-1:0] g_wide;
   logic          ren;

   assign wq_wide = from_gray(CW'(wq_gray));
   assign wq_bin  = wq_wide[PW-1:0];
   assign used    = wq_bin - rptr;
   assign empty   = (wq_bin == rptr);
   assign ren     = req && !empty;
   assign rptr_nx = rptr + PW'(1);
   assign g_wide  = to_gray(CW'(rptr_nx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr  <= '0;
         rgray <= '0;
      end else if (ren) begin
         rptr  <= rptr_nx;
         rgray <= g_wide[PW-1:0];
      end
   end
endmodule

// File: rtl/mwf_store.sv
`timescale 1ns/1ps
module mwf_store #(
   parameter int unsigned BW = 8,
   parameter int unsigned LANES = 4,
   parameter int unsigned DEPTH = 2048,
   parameter int unsigned AW = 11,
   parameter int unsigned LW = 2
) (
   input  logic                wclk,
   input  logic                wen,
   input  logic [AW-1:0]       waddr,
   input  logic [BW-1:0]       wdata,
   input  logic [AW-LW-1:0]    raddr,
   output logic [BW*LANES-1:0] rdata
);
   logic [BW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (wen) mem[waddr] <= wdata;
   end

   generate
      if (LANES == 1) begin : g_narrow
         assign rdata = mem[raddr];
      end else begin : g_wide
         for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            assign rdata[ln*BW +: BW] = mem[{raddr, LW'(ln)}];
         end
      end
   endgenerate
endmodule

// File: rtl/mw_async_fifo.sv
`timescale 1ns/1ps
module mw_async_fifo #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned LANES       = 4,
   parameter int unsigned DEPTH_BYTES = 2048,
   localparam int unsigned AW    = $clog2(DEPTH_BYTES),
   localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 0,
   localparam int unsigned WORDS = DEPTH_BYTES / LANES,
   localparam int unsigned PW    = AW - LW + 1
) (
   input  logic                    wr_clk,
   input  logic                    wr_rst_n,
   input  logic                    wr_req,
   input  logic [BYTE_W-1:0]       wr_data,
   output logic                    wr_full,
   output logic [AW:0]             wr_used,
   input  logic                    rd_clk,
   input  logic                    rd_rst_n,
   input  logic                    rd_req,
   output logic [BYTE_W*LANES-1:0] rd_data,
   output logic                    rd_empty,
   output logic [PW-1:0]           rd_used
);
   generate
      if ((1 << AW) != DEPTH_BYTES) begin : g_bad_depth
         $error("DEPTH_BYTES must be a power of two");
      end
      if (LANES < 2 || (1 << LW) != LANES) begin : g_bad_lanes
         $error("LANES must be a power of two of at least 2");
      end
      if (WORDS < 2) begin : g_bad_words
         $error("need at least two words of storage");
      end
   endgenerate

   logic          w_rst, r_rst;
   logic [AW:0]   w_ptr;
   logic [PW-1:0] w_gray, w_gray_rd;
   logic [PW-1:0] r_ptr, r_gray, r_gray_wr;
   logic          w_en;
   logic [AW-1:0] w_addr;

   mwf_rst_sync #(.STAGES(2)) u_wrst (.clk(wr_clk), .arst_n(wr_rst_n), .rst_n(w_rst));
   mwf_rst_sync #(.STAGES(2)) u_rrst (.clk(rd_clk), .arst_n(rd_rst_n), .rst_n(r_rst));

   mwf_wr_side #(.AW(AW), .LW(LW), .DEPTH(DEPTH_BYTES)) u_wr (
      .clk(wr_clk), .rst_n(w_rst), .req(wr_req), .rq_gray(r_gray_wr),
      .wen(w_en), .waddr(w_addr), .wptr(w_ptr), .wgray(w_gray),
      .full(wr_full), .used(wr_used)
   );

   mwf_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(r_rst), .d(w_gray), .q(w_gray_rd));
   mwf_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(w_rst), .d(r_gray), .q(r_gray_wr));

   mwf_rd_side #(.PW(PW)) u_rd (
      .clk(rd_clk), .rst_n(r_rst), .req(rd_req), .wq_gray(w_gray_rd),
      .rptr(r_ptr), .rgray(r_gray), .empty(rd_empty), .used(rd_used)
   );

   mwf_store #(.BW(BYTE_W), .LANES(LANES), .DEPTH(DEPTH_BYTES), .AW(AW), .LW(LW)) u_mem (
      .wclk(wr_clk), .wen(w_en), .waddr(w_addr), .wdata(wr_data),
      .raddr(r_ptr[PW-2:0]), .rdata(rd_data)
   );
endmodule

// File: rtl/mwf_checker.sv
`timescale 1ns/1ps
module mwf_checker #(
   parameter int unsigned AW = 11,
   parameter int unsigned PW = 10,
   parameter int unsigned DW = 32,
   parameter int unsigned DEPTH = 2048,
   parameter int unsigned WORDS = 512
) (
   input logic          wclk,
   input logic          rclk,
   input logic          wrst,
   input logic          rrst,
   input logic          wreq,
   input logic          rreq,
   input logic          wfull,
   input logic          rempty,
   input logic [AW:0]   wused,
   input logic [PW-1:0] rused,
   input logic [AW:0]   wptr,
   input logic [PW-1:0] rptr,
   input logic [PW-1:0] wgray,
   input logic [PW-1:0] rgray,
   input logic [DW-1:0] rdata
);
   // R5
   a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!wrst)
      wfull && wreq |=> $stable(wptr));
   // R6
   a_r6_no_underflow: assert property (@(posedge rclk) disable iff (!rrst)
      rempty && rreq |=> $stable(rptr));
   // R3
   a_r3_wr_gray_step: assert property (@(posedge wclk) disable iff (!wrst)
      $countones(wgray ^ $past(wgray)) <= 1);
   // R3
   a_r3_rd_gray_step: assert property (@(posedge rclk) disable iff (!rrst)
      $countones(rgray ^ $past(rgray)) <= 1);
   // R7
   a_r7_wr_bound: assert property (@(posedge wclk) disable iff (!wrst)
      wused <= (AW+1)'(DEPTH));
   // R7
   a_r7_rd_bound: assert property (@(posedge rclk) disable iff (!rrst)
      rused <= PW'(WORDS));
   // R4
   a_r4_hold_head: assert property (@(posedge rclk) disable iff (!rrst)
      !rempty && !rreq |=> $stable(rdata));
endmodule

bind mw_async_fifo mwf_checker #(
   .AW(AW), .PW(PW), .DW(BYTE_W*LANES), .DEPTH(DEPTH_BYTES), .WORDS(WORDS)
) u_chk (
   .wclk(wr_clk), .rclk(rd_clk), .wrst(w_rst), .rrst(r_rst),
   .wreq(wr_req), .rreq(rd_req), .wfull(wr_full), .rempty(rd_empty),
   .wused(wr_used), .rused(rd_used), .wptr(w_ptr), .rptr(r_ptr),
   .wgray(w_gray), .rgray(r_gray), .rdata(rd_data)
);

// File: tb/mw_async_fifo_test.sv
`timescale 1ns/1ps
module mw_async_fifo_test;
   logic        wr_clk = 1'b0, rd_clk = 1'b0;
   logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic        wr_req = 1'b0, rd_req = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        wr_full, rd_empty;
   logic [11:0] wr_used;
   logic [9:0]  rd_used;
   logic [31:0] rd_data;

   int n_chk = 0, n_bad = 0, wseq = 0, rseq = 0;
   bit done = 0;

   always #10 wr_clk = ~wr_clk;
   always #7  rd_clk = ~rd_clk;

   mw_async_fifo uut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_req(wr_req), .wr_data(wr_data),
      .wr_full(wr_full), .wr_used(wr_used),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_req(rd_req), .rd_data(rd_data),
      .rd_empty(rd_empty), .rd_used(rd_used)
   );

   function automatic logic [7:0] pat(input int s);
      return 8'((s * 37 + 11) & 255);
   endfunction

   function automatic logic [31:0] word_at(input int j);
      return {pat(4*j+3), pat(4*j+2), pat(4*j+1), pat(4*j)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push;
      @(negedge wr_clk);
      wr_req  = 1'b1;
      wr_data = pat(wseq);
      @(negedge wr_clk);
      wr_req  = 1'b0;
      wseq++;
   endtask

   task automatic pop(input string tag);
      @(negedge rd_clk);
      chk(tag, rd_data, word_at(rseq));
      rd_req = 1'b1;
      @(negedge rd_clk);
      rd_req = 1'b0;
      rseq++;
   endtask

   task automatic settle;
      repeat (6) @(negedge wr_clk);
      repeat (6) @(negedge rd_clk);
   endtask

   task automatic t_reset;
      settle();
      chk("R1 wr_full", 32'(wr_full), 32'd0);
      chk("R1 wr_used", 32'(wr_used), 32'd0);
      chk("R1 rd_empty", 32'(rd_empty), 32'd1);
      chk("R1 rd_used", 32'(rd_used), 32'd0);
   endtask

   task automatic t_partial;
      repeat (3) push();
      settle();
      chk("R2 rd_empty partial", 32'(rd_empty), 32'd1);
      chk("R2 rd_used partial", 32'(rd_used), 32'd0);
      chk("R7 wr_used bytes", 32'(wr_used), 32'd3);
      push();
      repeat (3) @(negedge rd_clk);
      chk("R3 visible in window", 32'(rd_empty), 32'd0);
      chk("R7 rd_used words", 32'(rd_used), 32'd1);
      chk("R4 showahead lane order", rd_data, word_at(rseq));
      pop("R4 pop first");
      chk("R4 advance to empty", 32'(rd_empty), 32'd1);
   endtask

   task automatic t_underflow;
      @(negedge rd_clk);
      rd_req = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge rd_clk);
         chk("R6 rd_used no wrap", 32'(rd_used), 32'd0);
         chk("R6 rd_empty held", 32'(rd_empty), 32'd1);
      end
      rd_req = 1'b0;
      repeat (4) push();
      settle();
      chk("R6 pointer not moved", rd_data, word_at(rseq));
      pop("R6 pop after underflow");
   endtask

   task automatic t_fill_drain;
      settle();
      repeat (2048) push();
      settle();
      chk("R7 wr_full at capacity", 32'(wr_full), 32'd1);
      chk("R7 wr_used capacity", 32'(wr_used), 32'd2048);
      chk("R7 rd_used capacity", 32'(rd_used), 32'd512);
      @(negedge wr_clk);
      wr_req  = 1'b1;
      wr_data = 8'hEE;
      @(negedge wr_clk);
      wr_req  = 1'b0;
      settle();
      chk("R5 wr_used after blocked write", 32'(wr_used), 32'd2048);
      for (int j = 0; j < 512; j++) pop("R8 drain order");
      settle();
      chk("R7 rd_empty after drain", 32'(rd_empty), 32'd1);
      chk("R7 rd_used after drain", 32'(rd_used), 32'd0);
      chk("R7 wr_used after drain", 32'(wr_used), 32'd0);
      chk("R7 wr_full after drain", 32'(wr_full), 32'd0);
      repeat (4) push();
      settle();
      chk("R5 alignment after blocked write", rd_data, word_at(rseq));
      pop("R5 pop after refill");
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #35;
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      t_reset();
      t_partial();
      t_underflow();
      t_fill_drain();
      finish_run();
   end

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end
endmodule